// File: doc/BRIEF.md
# Conditional Battery-Backup Switchover Controller

This block is the digital power-state controller of a supply supervisor. Analog comparators outside the block report four conditions as digital flags: the supply is under the reset threshold, the supply is within 50 mV of the battery, the supply has climbed more than 70 mV over the battery, and the power-fail comparator result. Every flag passes through a synchroniser inside the block. From these flags the block picks which of two power switches feeds the protected memory rail. The main switch connects the rail to the supply and the battery switch connects it to the backup cell. The block also drives the battery-on indicator, the low-line flag, the gated memory chip-enable and the power-fail output.

A host sets a backup-request input to say whether memory contents must survive the next power loss. The block samples this input only when the supply falls through the reset threshold, and ignores it at every other time. The sampled value then decides the outcome once the supply drops near the battery. A high value gives battery-backup mode, where the rail runs from the battery. A low value gives battery-saving mode, where both switches are open and the rail floats. The register holding the sampled value has no reset, so its contents are undetermined after a battery change. The mode register comes out of reset with both switches open. A board that never wants saving mode ties the request high, which matches the default of a floating pin.

Top module: `bkp_switch_ctrl`

## Requirements
- R1: While reset is held, and right after it, both switch enables are low, battery-on is low, low-line (active low) is low, the chip-enable output (active low) is high and the power-fail output (active low) is low.
- R2: The backup request is captured only on the rise of the synchronised under-threshold flag, that is, when the supply falls through the reset threshold. Changes to the request at any other time have no effect on the mode chosen later.
- R3: In normal mode, when the near-battery flag rises and the captured request is 1, the block enters battery-backup mode. In that mode the battery switch enable is 1, the main switch enable is 0 and battery-on is 1.
- R4: In normal mode, when the near-battery flag rises and the captured request is 0, the block enters battery-saving mode. In that mode both switch enables are 0 and battery-on is 0.
- R5: Backup mode and saving mode are both left only when the flag for supply above battery plus 70 mV is 1. The block then returns to normal mode, with the main switch enable at 1 and battery-on at 0. While neither battery flag is set, the mode does not change.
- R6: The chip-enable output equals the chip-enable input while the supply is over the reset threshold in normal mode. Otherwise it is held at 1.
- R7: Low-line (active low) is 1 exactly when the under-threshold flag is clear and the block is in normal mode.
- R8: The power-fail output follows the comparator input in normal mode and is held at 0 in backup and saving modes.
- R9: The two switch enables are never 1 in the same cycle.
- R10: If the supply crosses the reset threshold in the same synchronised cycle as it drops near the battery, the mode chosen uses the request captured at that crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vcc_low_i | input | 1 | Supply is under the reset threshold |
| vcc_near_bat_i | input | 1 | Supply is under battery + 50 mV |
| vcc_clear_bat_i | input | 1 | Supply is over battery + 70 mV |
| pf_ok_i | input | 1 | Power-fail comparator: 1 = monitored input is above its reference |
| backup_req_i | input | 1 | 1 = keep memory powered from the battery on the next power loss |
| ce_n_i | input | 1 | Memory chip-enable from the address decoder, active low |
| main_sw_en_o | output | 1 | Closes the supply-to-rail switch |
| batt_sw_en_o | output | 1 | Closes the battery-to-rail switch |
| batt_on_o | output | 1 | 1 while the rail runs from the battery |
| low_line_n_o | output | 1 | Low-supply flag, active low |
| ce_n_o | output | 1 | Gated memory chip-enable, active low |
| pfo_n_o | output | 1 | Power-fail output, active low |

## Verification
The fault that matters most in this block is a wrong captured request. It shows nothing at the ports when it happens. It shows up only at the next drop near the battery, when the block picks the wrong mode: battery-on and the battery switch stay low where backup was due, or the reverse. For this reason the bench changes the request before the crossing, at the crossing and after it, then takes the supply down and checks which mode was chosen. A wrong mode state shows up three clock edges after the flag changes, with the default two synchroniser stages: the switch enables, battery-on, low-line, chip-enable gating and the power-fail output all move together.

// File: rtl/bkp_pkg.sv
// Shared types and constants for the battery-backup switchover controller.
// Assumes the flag vector layout below is used by every submodule.
package bkp_pkg;

    // Power-path mode; the switch enables are decoded from this value.
    typedef enum logic [1:0] {
        MODE_MAIN = 2'd0,
        MODE_BATT = 2'd1,
        MODE_SAVE = 2'd2
    } pwr_mode_e;

    localparam int FLAG_W      = 5;
    localparam int F_BELOW_RST = 0;
    localparam int F_NEAR_BAT  = 1;
    localparam int F_CLEAR_BAT = 2;
    localparam int F_PF_OK     = 3;
    localparam int F_BKP_REQ   = 4;

    // Reset image of the flags: supply assumed absent, request defaults high.
    localparam logic [FLAG_W-1:0] FLAG_RST = 5'b10011;

endpackage

// File: rtl/bkp_flag_sync.sv
// Multi-stage synchroniser for the asynchronous comparator flags.
// Assumes each flag is a level that stays put for several clock periods;
// no bus coherence is promised across bits.
module bkp_flag_sync #(
    parameter int                WIDTH   = 5,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first stage samples the raw flags.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= d_i;
            end
        end else begin : g_next
            // Purpose: later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bkp_req_latch.sv
// Captures the backup request when the supply falls through the reset
// threshold. The captured bit has no reset: after a battery change its
// value is undetermined until the first crossing. The edge detector
// resets to "below", so a reset taken while the supply is low is not
// treated as a crossing.
module bkp_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic below_rst_s,
    input  logic bkp_req_s,
    output logic sel_backup_o,
    output logic latched_o
);

    logic prev_below_q;
    logic latched_q;
    logic capture;

    assign capture = below_rst_s & ~prev_below_q;

    // Purpose: remember the previous threshold flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_below_q <= 1'b1;
        else        prev_below_q <= below_rst_s;
    end

    // Purpose: hold the request sampled at the falling supply crossing.
    always_ff @(posedge clk) begin
        if (capture) latched_q <= bkp_req_s;
    end

    // Forward the fresh sample so a same-cycle switchover sees it.
    assign sel_backup_o = capture ? bkp_req_s : latched_q;
    assign latched_o    = latched_q;

endmodule

// File: rtl/bkp_mode_fsm.sv
// Three-state power-path sequencer. Leaves normal mode on the near-battery
// flag, picking backup or saving from the captured request; returns only on
// the clear-of-battery flag, giving the 50/70 mV hysteresis band.
module bkp_mode_fsm
    import bkp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      near_bat_s,
    input  logic      clear_bat_s,
    input  logic      sel_backup,
    output pwr_mode_e mode_o
);

    pwr_mode_e mode_q, mode_d;

    // Purpose: next-mode decision.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_MAIN: if (near_bat_s)  mode_d = sel_backup ? MODE_BATT : MODE_SAVE;
            MODE_BATT: if (clear_bat_s) mode_d = MODE_MAIN;
            MODE_SAVE: if (clear_bat_s) mode_d = MODE_MAIN;
            default:                    mode_d = MODE_SAVE;
        endcase
    end

    // Purpose: mode register, both switches open after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SAVE;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/bkp_out_gate.sv
// Decodes switch enables and status outputs from the mode, and gates the
// chip-enable and power-fail paths. Chip-enable stays combinational so the
// decoder-to-memory delay is not lengthened by a clock.
module bkp_out_gate
    import bkp_pkg::*;
(
    input  pwr_mode_e mode_i,
    input  logic      below_rst_s,
    input  logic      pf_ok_s,
    input  logic      ce_n_i,
    output logic      main_sw_en_o,
    output logic      batt_sw_en_o,
    output logic      batt_on_o,
    output logic      low_line_n_o,
    output logic      ce_n_o,
    output logic      pfo_n_o
);

    logic on_main;
    logic supply_good;

    // Purpose: one-hot style decode keeps the two switches exclusive.
    always_comb begin
        on_main      = (mode_i == MODE_MAIN);
        supply_good  = on_main & ~below_rst_s;
        main_sw_en_o = on_main;
        batt_sw_en_o = (mode_i == MODE_BATT);
        batt_on_o    = (mode_i == MODE_BATT);
        low_line_n_o = supply_good;
        ce_n_o       = ce_n_i | ~supply_good;
        pfo_n_o      = pf_ok_s & on_main;
    end

endmodule

// File: rtl/bkp_switch_ctrl.sv
// Top of the conditional battery-backup switchover controller.
// Assumes comparator flags are asynchronous levels; all are synchronised
// with SYNC_STAGES flops before use.
module bkp_switch_ctrl
    import bkp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_low_i,
    input  logic vcc_near_bat_i,
    input  logic vcc_clear_bat_i,
    input  logic pf_ok_i,
    input  logic backup_req_i,
    input  logic ce_n_i,
    output logic main_sw_en_o,
    output logic batt_sw_en_o,
    output logic batt_on_o,
    output logic low_line_n_o,
    output logic ce_n_o,
    output logic pfo_n_o
);

    logic [FLAG_W-1:0] flags_raw;
    logic [FLAG_W-1:0] flags_s;
    logic              sel_backup;
    logic              latched_w;
    pwr_mode_e         mode;

    always_comb begin
        flags_raw              = '0;
        flags_raw[F_BELOW_RST] = vcc_low_i;
        flags_raw[F_NEAR_BAT]  = vcc_near_bat_i;
        flags_raw[F_CLEAR_BAT] = vcc_clear_bat_i;
        flags_raw[F_PF_OK]     = pf_ok_i;
        flags_raw[F_BKP_REQ]   = backup_req_i;
    end

    bkp_flag_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(FLAG_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (flags_raw),
        .q_o  (flags_s)
    );

    bkp_req_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .below_rst_s (flags_s[F_BELOW_RST]),
        .bkp_req_s   (flags_s[F_BKP_REQ]),
        .sel_backup_o(sel_backup),
        .latched_o   (latched_w)
    );

    bkp_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .near_bat_s (flags_s[F_NEAR_BAT]),
        .clear_bat_s(flags_s[F_CLEAR_BAT]),
        .sel_backup (sel_backup),
        .mode_o     (mode)
    );

    bkp_out_gate u_gate (
        .mode_i      (mode),
        .below_rst_s (flags_s[F_BELOW_RST]),
        .pf_ok_s     (flags_s[F_PF_OK]),
        .ce_n_i      (ce_n_i),
        .main_sw_en_o(main_sw_en_o),
        .batt_sw_en_o(batt_sw_en_o),
        .batt_on_o   (batt_on_o),
        .low_line_n_o(low_line_n_o),
        .ce_n_o      (ce_n_o),
        .pfo_n_o     (pfo_n_o)
    );

endmodule

// File: rtl/bkp_switch_ctrl_chk.sv
// Property checker for bkp_switch_ctrl, attached by bind. Observes ports
// plus the synchronised flags and the captured request.
module bkp_switch_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic main_sw_en_o,
    input logic batt_sw_en_o,
    input logic batt_on_o,
    input logic low_line_n_o,
    input logic ce_n_o,
    input logic pfo_n_o,
    input logic below_rst_s,
    input logic near_bat_s,
    input logic clear_bat_s,
    input logic bkp_req_s,
    input logic latched_w
);

    // R9
    switch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_sw_en_o && batt_sw_en_o));

    // R3
    batt_on_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        batt_on_o |-> (batt_sw_en_o && !main_sw_en_o));

    // R5
    main_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_sw_en_o) |-> $past(clear_bat_s));

    // R3
    batt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_sw_en_o) |-> $past(near_bat_s));

    // R6
    ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !low_line_n_o |-> ce_n_o);

    // R8
    pfo_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_sw_en_o |-> !pfo_n_o);

    // R2
    req_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(below_rst_s) && $past(rst_n)) |=> (latched_w == $past(bkp_req_s)));

endmodule

bind bkp_switch_ctrl bkp_switch_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_sw_en_o(main_sw_en_o),
    .batt_sw_en_o(batt_sw_en_o),
    .batt_on_o   (batt_on_o),
    .low_line_n_o(low_line_n_o),
    .ce_n_o      (ce_n_o),
    .pfo_n_o     (pfo_n_o),
    .below_rst_s (flags_s[0]),
    .near_bat_s  (flags_s[1]),
    .clear_bat_s (flags_s[2]),
    .bkp_req_s   (flags_s[4]),
    .latched_w   (latched_w)
);

// File: tb/test_bkp_switch_ctrl.sv
// Scoreboard bench: a driver task applies a stimulus, waits for the
// synchroniser and mode register, and pushes the expected output word;
// a monitor process pops and compares against the ports.
module test_bkp_switch_ctrl;

    localparam int CLK_PERIOD  = 10;
    localparam int SYNC_STAGES = 2;
    localparam int SETTLE      = SYNC_STAGES + 2;
    localparam int WATCHDOG    = 5000;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_low_i = 1'b1, vcc_near_bat_i = 1'b1, vcc_clear_bat_i = 1'b0;
    logic pf_ok_i = 1'b0, backup_req_i = 1'b1, ce_n_i = 1'b0;
    logic main_sw_en_o, batt_sw_en_o, batt_on_o, low_line_n_o, ce_n_o, pfo_n_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    sb_item_t sbq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bkp_switch_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_bkp_switch_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .vcc_low_i      (vcc_low_i),
        .vcc_near_bat_i (vcc_near_bat_i),
        .vcc_clear_bat_i(vcc_clear_bat_i),
        .pf_ok_i        (pf_ok_i),
        .backup_req_i   (backup_req_i),
        .ce_n_i         (ce_n_i),
        .main_sw_en_o   (main_sw_en_o),
        .batt_sw_en_o   (batt_sw_en_o),
        .batt_on_o      (batt_on_o),
        .low_line_n_o   (low_line_n_o),
        .ce_n_o         (ce_n_o),
        .pfo_n_o        (pfo_n_o)
    );

    // Output word: {main, batt, batt_on, low_line_n, ce_n, pfo_n}
    // Input word:  {vcc_low, near_bat, clear_bat, pf_ok, backup_req, ce_n}
    task automatic step(input logic [5:0] stim, input logic [5:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        {vcc_low_i, vcc_near_bat_i, vcc_clear_bat_i, pf_ok_i, backup_req_i, ce_n_i} = stim;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
        it.exp = exp;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare each expected word with the ports when it arrives.
    initial begin
        forever begin
            sb_item_t it;
            logic [5:0] act;
            wait (sbq.size() > 0);
            it  = sbq.pop_front();
            act = {main_sw_en_o, batt_sw_en_o, batt_on_o, low_line_n_o, ce_n_o, pfo_n_o};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
            end
            checks++;
            if (main_sw_en_o && batt_sw_en_o) begin
                failures++;
                $display("FAIL R9 actual=both_on expected=exclusive");
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, supply absent
        step(6'b110010, 6'b000_010, "R1 reset state");
        // R5 hysteresis band holds saving mode
        step(6'b100010, 6'b000_010, "R5 band hold");
        step(6'b101010, 6'b100_010, "R5 clear of battery -> main");
        // R7 R6 above threshold
        step(6'b001010, 6'b100_100, "R7 R6 supply good");
        step(6'b001011, 6'b100_110, "R6 ce follows input high");
        // R8 power-fail follows comparator
        step(6'b001110, 6'b100_101, "R8 pf follows comparator");
        // R2 request changes above threshold are ignored
        step(6'b001100, 6'b100_101, "R2 request low ignored");
        step(6'b001110, 6'b100_101, "R2 request high ignored");
        // Falling crossing captures request = 1
        step(6'b101110, 6'b100_011, "R7 low line on crossing");
        step(6'b101100, 6'b100_011, "R2 request after crossing");
        // R3 backup mode, R8 pfo forced low
        step(6'b110100, 6'b011_010, "R3 R8 backup mode");
        step(6'b100100, 6'b011_010, "R5 backup holds in band");
        step(6'b101100, 6'b100_011, "R5 return to main");
        step(6'b001100, 6'b100_101, "R7 supply good again");
        // Crossing with request = 0, then request raised (ignored)
        step(6'b101100, 6'b100_011, "R2 capture low");
        step(6'b101110, 6'b100_011, "R2 request raise ignored");
        step(6'b110110, 6'b000_010, "R4 saving mode");
        step(6'b100110, 6'b000_010, "R4 saving holds in band");
        step(6'b001110, 6'b100_101, "R5 power up from saving");
        // R10 same-cycle crossing and drop
        step(6'b110110, 6'b011_010, "R10 same-cycle backup");
        step(6'b001100, 6'b100_101, "R10 restore");
        step(6'b110100, 6'b000_010, "R10 same-cycle saving");
        wait (sbq.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule